// File: doc/BRIEF.md
# In-Order Retirement Tracker

This block follows instructions from the moment they are dispatched until their register results come back, and then hands them out again in program order. Every dispatch lane can fire once per cycle. A firing lane may name a scalar destination, a float destination, or both, and an environment-call instruction adds a marker entry of its own. Each entry is stored in a circular buffer together with its PC, its instruction word and a register number in one unified space. Scalar registers sit at a scalar base, float registers at a float base, and environment-call markers at a third base.

Writeback ports carry a register index, a per-port base offset and data. They are handled in ascending port order. Each port completes the oldest entry that is still incomplete and names its target register. As a side effect, a port also completes an incomplete environment-call entry if its search reaches that entry first. Completed entries leave from the head in order through a valid/ready retire interface that is several records wide. The block stops taking dispatches while a worst-case cycle of allocations would not fit.

Top module: `retire_tracker`

## Requirements
- R1: After reset no retire slot is valid and `disp_ready` is high.
- R2: The unified register number is the scalar index plus SCALAR_BASE (0), the float index plus FLOAT_BASE (32), or ECALL_BASE (64) for an environment-call marker. A writeback port targets its index plus its own `wb_base`.
- R3: Within one cycle, entries are allocated in this order: first one float entry for every lane in ascending order that fires with a valid float destination, then a second pass over the lanes for scalar destinations. New entries are incomplete.
- R4: A firing lane whose valid scalar destination maps to unified register 0 allocates no scalar entry.
- R5: A firing lane whose instruction word is 32'h00000073 allocates an extra marker entry with register number ECALL_BASE. The marker is placed right after that lane's scalar entry.
- R6: For each writeback port in ascending order, the search runs from oldest to newest over incomplete entries. If the port is valid, the first entry whose register equals the target takes the port data, becomes complete, and ends that port's search.
- R7: If a port's search reaches an incomplete entry whose instruction word is 32'h00000073 before any match, that entry becomes complete and the search ends. This happens whether or not the port is valid.
- R8: Retire slot k (slot 0 oldest) is valid only when the k+1 oldest entries are all complete. Retirement therefore stops at the first incomplete entry. Up to RET_MAX records are shown per cycle, and all valid slots are removed when `ret_ready` is high. A held record stays stable.
- R9: `disp_ready` is high exactly when free entries are at least 3*LANES. Fire strobes are ignored while it is low.
- R10: A writeback in the same cycle as an allocation can complete the newly allocated entry. The record becomes visible on the retire slots in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_fire | input | LANES | Per-lane dispatch strobe |
| disp_pc | input | LANES x XLEN | Per-lane PC |
| disp_inst | input | LANES x XLEN | Per-lane instruction word |
| disp_sdst_vld | input | LANES | Scalar destination present |
| disp_sdst_idx | input | LANES x IDXW | Scalar destination index |
| disp_fdst_vld | input | LANES | Float destination present |
| disp_fdst_idx | input | LANES x IDXW | Float destination index |
| disp_ready | output | 1 | Room for a worst-case dispatch cycle |
| wb_valid | input | WPORTS | Writeback valid per port |
| wb_idx | input | WPORTS x IDXW | Writeback register index |
| wb_base | input | WPORTS x RW | Per-port base added to the index |
| wb_data | input | WPORTS x XLEN | Writeback data |
| ret_valid | output | RET_MAX | Retire slot valid, slot 0 oldest |
| ret_ready | input | 1 | Consumer takes all valid slots |
| ret_pc | output | RET_MAX x XLEN | Retired PC |
| ret_inst | output | RET_MAX x XLEN | Retired instruction word |
| ret_reg | output | RET_MAX x RW | Retired unified register number |
| ret_data | output | RET_MAX x XLEN | Retired result data |

## Verification
The checks assume that the float and scalar bases, with 5-bit indices, never wrap to register 0 through a float entry. This means a retired register of zero can only come from a faulty scalar filter. They also assume the consumer may hold `ret_ready` low for any number of cycles. The stimulus keeps fire strobes random even while `disp_ready` is low, so that the ignore rule is exercised. It draws register indices from a small set so that duplicate pending registers and oldest-match selection occur often, and it inserts environment-call words at a low rate.

// File: rtl/retire_tracker.sv
module retire_tracker #(
  parameter int LANES   = 2,
  parameter int WPORTS  = 2,
  parameter int DEPTH   = 16,
  parameter int RET_MAX = 2,
  parameter int XLEN    = 32,
  parameter int IDXW    = 5,
  parameter int RW      = 8,
  parameter logic [RW-1:0]   SCALAR_BASE = 8'd0,
  parameter logic [RW-1:0]   FLOAT_BASE  = 8'd32,
  parameter logic [RW-1:0]   ECALL_BASE  = 8'd64,
  parameter logic [XLEN-1:0] ECALL_WORD  = 32'h0000_0073
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [LANES-1:0]                 disp_fire,
  input  logic [LANES-1:0][XLEN-1:0]       disp_pc,
  input  logic [LANES-1:0][XLEN-1:0]       disp_inst,
  input  logic [LANES-1:0]                 disp_sdst_vld,
  input  logic [LANES-1:0][IDXW-1:0]       disp_sdst_idx,
  input  logic [LANES-1:0]                 disp_fdst_vld,
  input  logic [LANES-1:0][IDXW-1:0]       disp_fdst_idx,
  output logic                             disp_ready,
  input  logic [WPORTS-1:0]                wb_valid,
  input  logic [WPORTS-1:0][IDXW-1:0]      wb_idx,
  input  logic [WPORTS-1:0][RW-1:0]        wb_base,
  input  logic [WPORTS-1:0][XLEN-1:0]      wb_data,
  output logic [RET_MAX-1:0]               ret_valid,
  input  logic                             ret_ready,
  output logic [RET_MAX-1:0][XLEN-1:0]     ret_pc,
  output logic [RET_MAX-1:0][XLEN-1:0]     ret_inst,
  output logic [RET_MAX-1:0][RW-1:0]       ret_reg,
  output logic [RET_MAX-1:0][XLEN-1:0]     ret_data
);
  localparam int PW        = $clog2(DEPTH);
  localparam int CW        = $clog2(DEPTH + 1);
  localparam int ALLOC_MAX = 3 * LANES;

  typedef struct packed {
    logic            done;
    logic [XLEN-1:0] pc;
    logic [XLEN-1:0] inst;
    logic [XLEN-1:0] data;
    logic [RW-1:0]   rnum;
  } ent_t;

  ent_t           ent_q [DEPTH];
  ent_t           ent_d [DEPTH];
  logic [PW-1:0]  head_q, head_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [CW-1:0]  pops;

  assign disp_ready = (CW'(DEPTH) - cnt_q) >= CW'(ALLOC_MAX);

  always_comb begin
    logic run;
    logic [PW-1:0] slot;
    run  = 1'b1;
    pops = '0;
    for (int k = 0; k < RET_MAX; k++) begin
      slot = head_q + PW'(k);
      run  = run && (CW'(k) < cnt_q) && ent_q[slot].done;
      ret_valid[k] = run;
      ret_pc[k]    = ent_q[slot].pc;
      ret_inst[k]  = ent_q[slot].inst;
      ret_reg[k]   = ent_q[slot].rnum;
      ret_data[k]  = ent_q[slot].data;
      if (run && ret_ready) pops = pops + 1'b1;
    end
  end

  always_comb begin
    logic [CW-1:0]  n;
    logic [PW-1:0]  slot;
    logic [RW-1:0]  sreg, tgt;
    logic [LANES-1:0] go;
    logic stop;
    ent_d = ent_q;
    n     = '0;
    go    = disp_fire & {LANES{disp_ready}};
    for (int l = 0; l < LANES; l++) begin
      if (go[l] && disp_fdst_vld[l]) begin
        slot = head_q + PW'(cnt_q) + PW'(n);
        ent_d[slot].done = 1'b0;
        ent_d[slot].pc   = disp_pc[l];
        ent_d[slot].inst = disp_inst[l];
        ent_d[slot].data = '0;
        ent_d[slot].rnum = FLOAT_BASE + RW'(disp_fdst_idx[l]);
        n = n + 1'b1;
      end
    end
    for (int l = 0; l < LANES; l++) begin
      sreg = SCALAR_BASE + RW'(disp_sdst_idx[l]);
      if (go[l] && disp_sdst_vld[l] && sreg != '0) begin
        slot = head_q + PW'(cnt_q) + PW'(n);
        ent_d[slot].done = 1'b0;
        ent_d[slot].pc   = disp_pc[l];
        ent_d[slot].inst = disp_inst[l];
        ent_d[slot].data = '0;
        ent_d[slot].rnum = sreg;
        n = n + 1'b1;
      end
      if (go[l] && disp_inst[l] == ECALL_WORD) begin
        slot = head_q + PW'(cnt_q) + PW'(n);
        ent_d[slot].done = 1'b0;
        ent_d[slot].pc   = disp_pc[l];
        ent_d[slot].inst = disp_inst[l];
        ent_d[slot].data = '0;
        ent_d[slot].rnum = ECALL_BASE;
        n = n + 1'b1;
      end
    end
    for (int p = 0; p < WPORTS; p++) begin
      tgt  = RW'(wb_idx[p]) + wb_base[p];
      stop = 1'b0;
      for (int k = 0; k < DEPTH; k++) begin
        slot = head_q + PW'(k);
        if (!stop && (CW'(k) < cnt_q + n) && !ent_d[slot].done) begin
          if (wb_valid[p] && ent_d[slot].rnum == tgt) begin
            ent_d[slot].data = wb_data[p];
            ent_d[slot].done = 1'b1;
            stop = 1'b1;
          end else if (ent_d[slot].inst == ECALL_WORD) begin
            ent_d[slot].done = 1'b1;
            stop = 1'b1;
          end
        end
      end
    end
    cnt_d  = cnt_q + n - pops;
    head_d = head_q + PW'(pops);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= '0;
    end else begin
      head_q <= head_d;
      cnt_q  <= cnt_d;
      for (int k = 0; k < DEPTH; k++) ent_q[k] <= ent_d[k];
    end
  end
endmodule

// File: rtl/retire_tracker_chk.sv
module retire_tracker_chk #(
  parameter int DEPTH   = 16,
  parameter int LANES   = 2,
  parameter int RET_MAX = 2,
  parameter int XLEN    = 32,
  parameter int RW      = 8,
  parameter int CW      = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               disp_ready,
  input logic               ret_ready,
  input logic [RET_MAX-1:0] ret_valid,
  input logic [XLEN-1:0]    ret_pc0,
  input logic [RW-1:0]      ret_reg0,
  input logic [CW-1:0]      cnt
);
  a_r8_valid_prefix: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + RET_MAX'(1)) & ret_valid) == '0);

  a_r8_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid[0] && !ret_ready) |=> (ret_valid[0] && $stable(ret_pc0) && $stable(ret_reg0)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r9_stall_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_ready |=> cnt <= $past(cnt));

  a_r4_no_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid[0] |-> ret_reg0 != '0);
endmodule

bind retire_tracker retire_tracker_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .RET_MAX(RET_MAX), .XLEN(XLEN), .RW(RW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .disp_ready(disp_ready), .ret_ready(ret_ready),
  .ret_valid(ret_valid), .ret_pc0(ret_pc[0]), .ret_reg0(ret_reg[0]), .cnt(cnt_q)
);

// File: tb/retire_tracker_tb.sv
module retire_tracker_tb;
  localparam int PERIOD = 10;
  localparam logic [31:0] ECALL = 32'h73;

  logic clk = 0, rst_n = 0;
  logic [1:0] fire, sv, fv, wbv, rv;
  logic [1:0][31:0] pc, inst, wbd, rpc, rinst, rdata;
  logic [1:0][4:0] sidx, fidx, wbi;
  logic [1:0][7:0] wbb, rreg;
  logic rdy, rr;

  always #(PERIOD/2) clk = ~clk;

  retire_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .disp_fire(fire), .disp_pc(pc), .disp_inst(inst),
    .disp_sdst_vld(sv), .disp_sdst_idx(sidx), .disp_fdst_vld(fv), .disp_fdst_idx(fidx),
    .disp_ready(rdy), .wb_valid(wbv), .wb_idx(wbi), .wb_base(wbb), .wb_data(wbd),
    .ret_valid(rv), .ret_ready(rr), .ret_pc(rpc), .ret_inst(rinst), .ret_reg(rreg),
    .ret_data(rdata)
  );

  typedef struct { logic [31:0] pc, inst, data; logic [7:0] r; bit done; } m_t;
  m_t q[$];
  int nchk = 0, nerr = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void push(logic [31:0] p, logic [31:0] i, logic [7:0] r);
    m_t e;
    e.pc = p; e.inst = i; e.data = 0; e.r = r; e.done = 0;
    q.push_back(e);
  endfunction

  task automatic compare();
    bit ok = 1;
    chk("R9 disp_ready", 32'(rdy), 32'((16 - q.size()) >= 6));
    for (int k = 0; k < 2; k++) begin
      bit ev = ok && (k < q.size()) && q[k].done;
      ok = ev;
      chk("R8 ret_valid", 32'(rv[k]), 32'(ev));
      if (ev) begin
        chk("R3 ret_pc", rpc[k], q[k].pc);
        chk("R5 ret_inst", rinst[k], q[k].inst);
        chk("R2 ret_reg", 32'(rreg[k]), 32'(q[k].r));
        chk("R6 ret_data", rdata[k], q[k].data);
      end
    end
  endtask

  task automatic step();
    bit r = (16 - q.size()) >= 6;
    if (rr) for (int k = 0; k < 2; k++) if (q.size() > 0 && q[0].done) void'(q.pop_front());
    if (r) begin
      for (int l = 0; l < 2; l++) if (fire[l] && fv[l]) push(pc[l], inst[l], 8'd32 + 8'(fidx[l]));
      for (int l = 0; l < 2; l++) begin
        if (fire[l] && sv[l] && sidx[l] != 0) push(pc[l], inst[l], 8'(sidx[l]));
        if (fire[l] && inst[l] == ECALL) push(pc[l], inst[l], 8'd64);
      end
    end
    for (int p = 0; p < 2; p++) begin
      logic [7:0] t = 8'(wbi[p]) + wbb[p];
      for (int k = 0; k < q.size(); k++) begin
        if (q[k].done) continue;
        if (wbv[p] && q[k].r == t) begin q[k].data = wbd[p]; q[k].done = 1; break; end
        if (q[k].inst == ECALL) begin q[k].done = 1; break; end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic clear();
    fire = 0; sv = 0; fv = 0; wbv = 0; pc = 0; inst = 0; sidx = 0; fidx = 0;
    wbi = 0; wbb = 0; wbd = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    clear(); rr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    chk("R1 ret_valid after reset", 32'(rv), 0);
    chk("R1 disp_ready after reset", 32'(rdy), 1);

    // R3 / R10: float-first order, same-cycle completion
    fire = 2'b11; pc[0] = 32'h100; pc[1] = 32'h104; inst[0] = 32'h13; inst[1] = 32'h13;
    fv = 2'b11; fidx[0] = 3; fidx[1] = 5; sv = 2'b01; sidx[0] = 4;
    wbv = 2'b01; wbi[0] = 3; wbb[0] = 32; wbd[0] = 32'hAA;
    step();
    chk("R10 same-cycle completion", 32'(rv[0]), 1);
    chk("R10 same-cycle reg", 32'(rreg[0]), 35);
    clear();
    wbv = 2'b11; wbi[0] = 4; wbb[0] = 0; wbd[0] = 32'hBB; wbi[1] = 5; wbb[1] = 32; wbd[1] = 32'hCC;
    step();
    chk("R3 second float entry", 32'(rreg[1]), 37);
    clear(); rr = 1;
    step();
    chk("R3 scalar after floats", 32'(rreg[0]), 4);
    chk("R6 scalar data", rdata[0], 32'hBB);
    step();

    // R4: zero scalar register allocates nothing
    clear(); fire = 2'b01; sv = 2'b01; sidx[0] = 0; pc[0] = 32'h200;
    step();
    clear(); fire = 2'b01; fv = 2'b01; fidx[0] = 1; pc[0] = 32'h204;
    wbv = 2'b01; wbi[0] = 1; wbb[0] = 32; wbd[0] = 32'h11;
    step();
    chk("R4 no zero-reg entry blocks head", 32'(rv[0]), 1);
    chk("R4 head reg", 32'(rreg[0]), 33);
    clear(); step();

    // R5 / R7: environment-call marker placement and side-effect completion
    rr = 0;
    fire = 2'b11; inst[0] = ECALL; pc[0] = 32'h300; sv = 2'b01; sidx[0] = 2;
    pc[1] = 32'h304; inst[1] = 32'h13; fv = 2'b10; fidx[1] = 6;
    step();
    chk("R7 float head still pending", 32'(rv[0]), 0);
    clear(); wbv = 2'b01; wbi[0] = 6; wbb[0] = 32; wbd[0] = 32'h66;
    step();
    chk("R7 ecall-word entries completed without writeback", 32'(rv), 3);
    chk("R5 scalar entry of ecall lane", 32'(rreg[1]), 2);
    clear(); rr = 1;
    step();
    chk("R5 marker after scalar entry", 32'(rreg[0]), 64);
    step();

    // R9: fill until dispatch is refused, fires then ignored
    rr = 0; clear();
    for (int c = 0; c < 8; c++) begin
      fire = 2'b11; fv = 2'b11; fidx[0] = 7; fidx[1] = 7; pc[0] = 32'h400 + 8*c; pc[1] = 32'h404 + 8*c;
      step();
    end
    chk("R9 ready low when nearly full", 32'(rdy), 0);
    clear(); rr = 1; wbv = 2'b11; wbi[0] = 7; wbi[1] = 7; wbb[0] = 32; wbb[1] = 32;
    for (int c = 0; c < 10; c++) begin wbd[0] = 32'h500 + c; wbd[1] = 32'h600 + c; step(); end
    clear(); step();

    // random traffic
    void'($urandom(32'd1234));
    for (int c = 0; c < 4000; c++) begin
      rr = ($urandom % 4) != 0;
      for (int l = 0; l < 2; l++) begin
        fire[l] = $urandom % 2; sv[l] = $urandom % 2; fv[l] = ($urandom % 3) == 0;
        sidx[l] = 5'($urandom % 4); fidx[l] = 5'($urandom % 4);
        pc[l] = $urandom; inst[l] = ($urandom % 16 == 0) ? ECALL : $urandom;
      end
      for (int p = 0; p < 2; p++) begin
        wbv[p] = $urandom % 2; wbi[p] = 5'($urandom % 4);
        wbb[p] = ($urandom % 2) ? 8'd32 : 8'd0; wbd[p] = $urandom;
      end
      step();
    end
    clear(); rr = 1;
    step();

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule